// File: doc/BRIEF.md
# Buffered Edge Input Capture Unit

This block records when things happen on four input pins. Each pin is resynchronised to the local clock. When the selected transition appears, the value of an external 16-bit free-running counter is stored in that channel's read-only capture register. At the same time the channel's capture flag is raised. The interrupt request line is active while any raised flag has its enable bit set. Software reads the registers and flags through plain output ports and drops a flag with a one-cycle clear strobe.

Channels C and D have a second role. Each can become a history register for channel A or channel B. In that mode the primary channel captures on both transitions of its pin. Every capture pushes the primary register's previous contents into its partner, so software gets two consecutive timestamps, for example a pulse's start and end. The partner channel's own pin is then disregarded.

Top module: `edge_capture_unit`

## Requirements
- R1: After reset all four capture registers read 0x0000, all flags are 0 and the interrupt request is 0. The synchronizer stages also reset to 0.
- R2: A level change on a pin that is first sampled at clock edge k takes effect at edge k+2. If it is a valid edge, the channel's register is loaded at edge k+2 with the counter value present at that edge. Without a capture, a register keeps its value.
- R3: For a channel that is not buffered, edge-select bit value 1 selects a low-to-high transition and value 0 selects a high-to-low transition. The unselected transition has no effect on the register or the flag. Bit i of the edge-select, enable, clear and flag vectors belongs to channel i, where A=0, B=1, C=2 and D=3.
- R4: A capture sets the channel's flag. A clear strobe bit drops the flag in the following cycle. When a capture and a clear for the same channel occur in the same cycle, the flag stays set.
- R5: The interrupt request is 1 exactly when at least one channel has both its flag and its interrupt-enable bit set.
- R6: When buffer-enable bit 0 is set (C paired with A) or bit 1 is set (D paired with B), the primary channel captures on both transitions. On each such capture, the partner register receives the primary register's old value in the same cycle that the primary register receives the counter value.
- R7: While a partner channel is in buffer mode, transitions on its own pin change neither its register nor its flag. The transfer into it does not set its flag either.
- R8: Channels operate independently, so simultaneous valid edges on several pins load all the affected registers in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frc_i | input | 16 | Free-running counter value to be timestamped |
| cap_pin_i | input | 4 | Asynchronous capture pins, bit 0 = A ... bit 3 = D |
| edge_rise_i | input | 4 | Per-channel edge select: 1 rising, 0 falling |
| irq_en_i | input | 4 | Per-channel interrupt enable |
| buf_en_i | input | 2 | Bit 0: C buffers A; bit 1: D buffers B |
| flag_clr_i | input | 4 | Per-channel flag clear strobe |
| cap_a_o | output | 16 | Capture register A |
| cap_b_o | output | 16 | Capture register B |
| cap_c_o | output | 16 | Capture register C (or A history) |
| cap_d_o | output | 16 | Capture register D (or B history) |
| flag_o | output | 4 | Capture flags |
| irq_o | output | 1 | Interrupt request |

## Verification
Single-channel steps with rising and falling selection tell whether the polarity decode is correct. They also expose a stage that was added to or lost from the synchronizer, because the counter value stored would be off by one. Simultaneous edges on all four pins show whether the channels are truly independent. Buffered sequences tell apart a shift that moves the old primary value from one that copies the new one, and they show whether a partner pin leaks through in buffer mode. Random pin activity is then mixed with random clears, enables and mode switches, which probes the collision between a clear and a set and the changes of mode while an edge is still in flight.

// File: rtl/ecap_pkg.sv
package ecap_pkg;
  localparam int NUM_CH    = 4;
  localparam int BUF_PAIRS = NUM_CH / 2;

  // Decide whether a detected transition is a capture event.
  function automatic logic edge_valid(input logic rise, input logic fall,
                                      input logic rise_sel, input logic both);
    if (both) return rise | fall;
    return rise_sel ? rise : fall;
  endfunction

  // Next flag state: a set in the same cycle overrides a clear.
  function automatic logic flag_next(input logic q, input logic set,
                                     input logic clr);
    return set | (q & ~clr);
  endfunction

  // Interrupt request from flags and enables.
  function automatic logic irq_any(input logic [NUM_CH-1:0] flags,
                                   input logic [NUM_CH-1:0] en);
    return |(flags & en);
  endfunction
endpackage

// File: rtl/ecap_sync_edge.sv
module ecap_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);
  localparam int LAST = STAGES;

  logic [LAST:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[LAST-1:0], pin_i};
  end

  logic cur_lvl, prev_lvl;
  assign cur_lvl  = chain_q[LAST-1];
  assign prev_lvl = chain_q[LAST];
  assign rise_o   = cur_lvl & ~prev_lvl;
  assign fall_o   = ~cur_lvl & prev_lvl;
endmodule

// File: rtl/ecap_cap_reg.sv
module ecap_cap_reg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] data_i,
  input  logic         set_i,
  input  logic         clr_i,
  output logic [W-1:0] value_o,
  output logic         flag_o
);
  import ecap_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      value_o <= '0;
      flag_o  <= 1'b0;
    end else begin
      if (load_i) value_o <= data_i;
      flag_o <= flag_next(flag_o, set_i, clr_i);
    end
  end
endmodule

// File: rtl/edge_capture_unit.sv
module edge_capture_unit #(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [CNT_W-1:0]           frc_i,
  input  logic [ecap_pkg::NUM_CH-1:0]    cap_pin_i,
  input  logic [ecap_pkg::NUM_CH-1:0]    edge_rise_i,
  input  logic [ecap_pkg::NUM_CH-1:0]    irq_en_i,
  input  logic [ecap_pkg::BUF_PAIRS-1:0] buf_en_i,
  input  logic [ecap_pkg::NUM_CH-1:0]    flag_clr_i,
  output logic [CNT_W-1:0]           cap_a_o,
  output logic [CNT_W-1:0]           cap_b_o,
  output logic [CNT_W-1:0]           cap_c_o,
  output logic [CNT_W-1:0]           cap_d_o,
  output logic [ecap_pkg::NUM_CH-1:0]    flag_o,
  output logic                       irq_o
);
  import ecap_pkg::*;

  // Named internal events, observed by the bound checker.
  logic [NUM_CH-1:0]    rise_det, fall_det;
  logic [NUM_CH-1:0]    cap_evt;
  logic [BUF_PAIRS-1:0] xfer_evt;
  logic [NUM_CH-1:0]    load_en;
  logic [CNT_W-1:0]     load_val [NUM_CH];
  logic [CNT_W-1:0]     cap_q    [NUM_CH];

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    ecap_sync_edge #(.STAGES(SYNC_STAGES)) i_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .pin_i  (cap_pin_i[ch]),
      .rise_o (rise_det[ch]),
      .fall_o (fall_det[ch])
    );

    if (ch < BUF_PAIRS) begin : g_primary
      // Primary channel: buffer mode widens detection to both edges.
      assign cap_evt[ch]  = edge_valid(rise_det[ch], fall_det[ch],
                                       edge_rise_i[ch], buf_en_i[ch]);
      assign load_en[ch]  = cap_evt[ch];
      assign load_val[ch] = frc_i;
    end else begin : g_partner
      localparam int SRC = ch - BUF_PAIRS;
      logic paired;
      assign paired        = buf_en_i[SRC];
      assign cap_evt[ch]   = ~paired & edge_valid(rise_det[ch], fall_det[ch],
                                                  edge_rise_i[ch], 1'b0);
      assign xfer_evt[SRC] = paired & cap_evt[SRC];
      assign load_en[ch]   = cap_evt[ch] | xfer_evt[SRC];
      assign load_val[ch]  = xfer_evt[SRC] ? cap_q[SRC] : frc_i;
    end

    ecap_cap_reg #(.W(CNT_W)) i_reg (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (load_en[ch]),
      .data_i  (load_val[ch]),
      .set_i   (cap_evt[ch]),
      .clr_i   (flag_clr_i[ch]),
      .value_o (cap_q[ch]),
      .flag_o  (flag_o[ch])
    );
  end

  assign cap_a_o = cap_q[0];
  assign cap_b_o = cap_q[1];
  assign cap_c_o = cap_q[2];
  assign cap_d_o = cap_q[3];
  assign irq_o   = irq_any(flag_o, irq_en_i);
endmodule

// File: rtl/ecap_checker.sv
module ecap_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] frc_i,
  input logic [3:0]       irq_en_i,
  input logic [1:0]       buf_en_i,
  input logic [3:0]       flag_clr_i,
  input logic [3:0]       cap_evt,
  input logic [1:0]       xfer_evt,
  input logic [CNT_W-1:0] cap_a_o,
  input logic [CNT_W-1:0] cap_b_o,
  input logic [CNT_W-1:0] cap_c_o,
  input logic [CNT_W-1:0] cap_d_o,
  input logic [3:0]       flag_o,
  input logic             irq_o
);
  logic [CNT_W-1:0] caps [4];
  assign caps[0] = cap_a_o;
  assign caps[1] = cap_b_o;
  assign caps[2] = cap_c_o;
  assign caps[3] = cap_d_o;

  p_reset_flags_r1: assert property (@(posedge clk) $rose(rst_n) |-> flag_o == 4'b0);

  for (genvar i = 0; i < 4; i++) begin : g_chan
    p_capture_value_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cap_evt[i] |=> caps[i] == $past(frc_i));
    p_flag_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
      cap_evt[i] |=> flag_o[i]);
    p_flag_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_clr_i[i] && !cap_evt[i]) |=> !flag_o[i]);
  end

  for (genvar j = 0; j < 2; j++) begin : g_pair
    p_primary_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !cap_evt[j] |=> $stable(caps[j]));
    p_partner_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!cap_evt[j+2] && !xfer_evt[j]) |=> $stable(caps[j+2]));
    p_buffer_shift_r6: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_evt[j] |=> caps[j+2] == $past(caps[j]));
    p_buffer_pair_r6: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_evt[j] |-> cap_evt[j] && buf_en_i[j]);
    p_partner_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      buf_en_i[j] |-> !cap_evt[j+2]);
  end

  p_irq_source_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (flag_o & irq_en_i) != 4'b0);
  p_irq_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_o == 4'b0) |-> !irq_o);
endmodule

bind edge_capture_unit ecap_checker #(.CNT_W(CNT_W)) i_ecap_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .frc_i      (frc_i),
  .irq_en_i   (irq_en_i),
  .buf_en_i   (buf_en_i),
  .flag_clr_i (flag_clr_i),
  .cap_evt    (cap_evt),
  .xfer_evt   (xfer_evt),
  .cap_a_o    (cap_a_o),
  .cap_b_o    (cap_b_o),
  .cap_c_o    (cap_c_o),
  .cap_d_o    (cap_d_o),
  .flag_o     (flag_o),
  .irq_o      (irq_o)
);

// File: tb/test_edge_capture_unit.sv
module test_edge_capture_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] frc = 16'h1000;
  logic [3:0]  pin = '0, esel = '0, ien = '0, clr = '0;
  logic [1:0]  ben = '0;
  logic [15:0] ca, cb, cc, cd;
  logic [3:0]  flg;
  logic        irq;

  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  edge_capture_unit i_edge_capture_unit (
    .clk(clk), .rst_n(rst_n), .frc_i(frc), .cap_pin_i(pin),
    .edge_rise_i(esel), .irq_en_i(ien), .buf_en_i(ben), .flag_clr_i(clr),
    .cap_a_o(ca), .cap_b_o(cb), .cap_c_o(cc), .cap_d_o(cd),
    .flag_o(flg), .irq_o(irq)
  );

  // Reference state
  logic        m_s1 [4], m_s2 [4], m_pv [4];
  logic [15:0] m_cap [4];
  logic [3:0]  m_flag;

  function automatic logic hit(logic was, logic now, logic want_rise, logic any);
    if (was == now) return 1'b0;
    if (any) return 1'b1;
    return (now == want_rise);
  endfunction

  task automatic check(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 4; i++) begin
      m_s1[i] = 0; m_s2[i] = 0; m_pv[i] = 0; m_cap[i] = '0;
    end
    m_flag = '0;
  endtask

  task automatic model_edge();
    logic [3:0]  ev;
    logic [15:0] nc [4];
    for (int i = 0; i < 4; i++) begin
      if (i >= 2 && ben[i-2]) ev[i] = 1'b0;
      else ev[i] = hit(m_pv[i], m_s2[i], esel[i], (i < 2) ? ben[i] : 1'b0);
    end
    for (int i = 0; i < 4; i++) nc[i] = m_cap[i];
    for (int i = 0; i < 2; i++) if (ev[i]) nc[i] = frc;
    for (int i = 2; i < 4; i++) begin
      if (ben[i-2] && ev[i-2]) nc[i] = m_cap[i-2];
      else if (ev[i]) nc[i] = frc;
    end
    for (int i = 0; i < 4; i++) begin
      m_cap[i] = nc[i];
      m_pv[i] = m_s2[i]; m_s2[i] = m_s1[i]; m_s1[i] = pin[i];
    end
    m_flag = ev | (m_flag & ~clr);
  endtask

  task automatic compare_all();
    check(ca == m_cap[0], "R2", "cap_a", ca, m_cap[0]);
    check(cb == m_cap[1], "R2", "cap_b", cb, m_cap[1]);
    check(cc == m_cap[2], ben[0] ? "R6" : "R2", "cap_c", cc, m_cap[2]);
    check(cd == m_cap[3], ben[1] ? "R6" : "R2", "cap_d", cd, m_cap[3]);
    check(flg == m_flag, "R4", "flags", flg, m_flag);
    check(irq == |(m_flag & ien), "R5", "irq", irq, |(m_flag & ien));
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    frc = frc + 16'd1;
    compare_all();
  endtask

  task automatic steps(int n);
    for (int k = 0; k < n; k++) step();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] f0, olda, keepc;
    void'($urandom(32'd1977));
    model_reset();
    repeat (3) @(negedge clk);
    // R1 reset state
    check(ca == 0 && cb == 0 && cc == 0 && cd == 0, "R1", "caps", ca | cb | cc | cd, 0);
    check(flg == 0, "R1", "flags", flg, 0);
    check(irq == 0, "R1", "irq", irq, 0);
    rst_n = 1'b1;
    ien = 4'hF;

    // R3: rising selected on A, default falling on B
    esel = 4'b0001;
    pin[0] = 1; steps(4);
    check(flg[0] == 1, "R3", "A rising selected", flg[0], 1);
    clr = 4'hF; step(); clr = 0;
    pin[0] = 0; steps(4);
    check(flg[0] == 0, "R3", "A falling ignored", flg[0], 0);
    pin[1] = 1; steps(4);
    check(flg[1] == 0, "R3", "B rising ignored", flg[1], 0);
    pin[1] = 0; steps(4);
    check(flg[1] == 1, "R3", "B falling default", flg[1], 1);

    // R2 latency and counter value on C
    clr = 4'hF; step(); clr = 0;
    pin[2] = 1; steps(4);
    pin[2] = 0; f0 = frc;
    steps(2);
    check(flg[2] == 0, "R2", "no capture before k+2", flg[2], 0);
    step();
    check(flg[2] == 1, "R2", "flag at k+2", flg[2], 1);
    check(cc == f0 + 16'd2, "R2", "counter at k+2", cc, f0 + 16'd2);

    // R4 set wins over clear
    clr = 4'hF; step(); clr = 0;
    pin[2] = 1; steps(4);
    pin[2] = 0; steps(2);
    clr = 4'b0100; step(); clr = 0;
    check(flg[2] == 1, "R4", "set beats clear", flg[2], 1);
    step();
    check(flg[2] == 1, "R4", "flag held", flg[2], 1);

    // R6 buffer shift on A, both edges
    clr = 4'hF; step(); clr = 0;
    ben = 2'b01; steps(2);
    olda = ca;
    pin[0] = 1; steps(4);
    check(cc == olda, "R6", "C got old A", cc, olda);
    check(flg[0] == 1, "R6", "A captured rising in buffer mode", flg[0], 1);
    olda = ca;
    pin[0] = 0; steps(4);
    check(cc == olda, "R6", "C got old A on fall", cc, olda);

    // R7 partner pin ignored while buffered
    clr = 4'hF; step(); clr = 0;
    keepc = cc;
    pin[2] = 1; steps(4);
    pin[2] = 0; steps(4);
    check(cc == keepc, "R7", "C unchanged", cc, keepc);
    check(flg[2] == 0, "R7", "C flag quiet", flg[2], 0);

    // R8 simultaneous captures
    ben = 0; esel = 0;
    pin = 4'hF; steps(4);
    clr = 4'hF; step(); clr = 0;
    pin = 4'h0; f0 = frc; steps(3);
    check(ca == f0 + 16'd2 && cb == f0 + 16'd2, "R8", "A/B same cycle", ca, f0 + 16'd2);
    check(cc == f0 + 16'd2 && cd == f0 + 16'd2, "R8", "C/D same cycle", cd, f0 + 16'd2);
    check(flg == 4'hF, "R8", "all flags", flg, 4'hF);

    // Random phase
    for (int n = 0; n < 4000; n++) begin
      for (int i = 0; i < 4; i++) if ($urandom_range(7) == 0) pin[i] = ~pin[i];
      clr = ($urandom_range(5) == 0) ? 4'($urandom) : 4'h0;
      if ($urandom_range(60) == 0) begin
        esel = 4'($urandom); ben = 2'($urandom); ien = 4'($urandom);
      end
      step();
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule